// File: doc/BRIEF.md
# System Clock Switch Controller

This block produces the system clock from one of up to eight source clocks and divides it by a programmable post-divider. Software picks a source by writing its number and a start bit. The controller first checks that the chosen source reports itself ready. It then hands the output over glitch-free: the old source is gated off while its clock is low, the controller waits for confirmation, and only then is the new source gated on while its clock is low. If the target is not ready, the request is refused. The start bit still clears, and the current-source field keeps its old value.

The post-divider can change in a single jump or walk one divisor step at a time toward its target. Each intermediate divisor is held for a programmable number of output cycles. Walking is enabled separately for the two directions. A busy flag covers the whole time the change takes. The divided clock is formed by gating the selected source with an enable that is registered on the falling edge. The output therefore pulses once every N source cycles, and divide-by-one passes the source straight through.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the requested and current source fields read 0, the start bit reads 0, the divider field reads 0, busy reads 0, and clk_out runs at the period of source 0.
- R2: A switch to a ready source ends with the current-source field (register 0, bits [6:4]) equal to the requested one (bits [2:0]). clk_out then runs at that source's period times the divisor.
- R3: A switch to a source whose ready input is low is refused. The start bit clears, the current-source field keeps its old value, and the clk_out period is unchanged.
- R4: Writing register 0 with bit 7 set starts a switch. Bit 7 reads 1 during the attempt and is cleared by hardware when the attempt ends. Writes to register 0 during an attempt are ignored.
- R5: The divider field (register 1, bits [3:0]) divides the output by its value plus one. Without walking, the new divisor takes effect at the next output-cycle boundary.
- R6: Busy (register 1, bit 15) reads 1 from the cycle after a divider write until the target divisor is in effect, and then returns to 0.
- R7: Writes to register 1 while busy is 1 are ignored.
- R8: When bit 5 is set, a divisor increase walks up one step per change. Each intermediate divisor lasts step+1 output cycles, where step is register 1 bits [10:8].
- R9: When bit 4 is set, a divisor decrease walks down in the same way.
- R10: When the enable bit for the needed direction is clear, the divisor jumps straight to its target at one boundary.
- R11: clk_out never shows a high or low phase shorter than half the period of the fastest source, and no two sources are gated onto the output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock |
| rst | input | 1 | Synchronous active-high reset, synchronized into every clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 source control, 1 divider control |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target, same encoding as wr_sel |
| rd_data | output | 16 | Registered read data, valid one cycle after rd_sel |
| src_clk | input | SRC_N | Source clocks |
| src_rdy | input | SRC_N | Per-source ready flags (asynchronous) |
| clk_out | output | 1 | Divided, glitch-free system clock |

## Verification
The hardest situations to reach are the ones where the divided clock changes period in the middle of a walk. The divisor sequence is only visible as the spacing of clk_out edges, and its phase relative to the divider write is not known in advance. The bench therefore timestamps every clk_out rising edge during a change and converts each interval into a count of source cycles. It skips the intervals that still carry the old divisor, then compares what follows against the step-by-step sequence computed from the old value, the target, the direction enables and the step field. A refused switch is reached by dropping one source's ready input before requesting that source.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int REG_W    = 16;
  localparam int CUR_LSB  = 4;
  localparam int SWEN_BIT = 7;
  localparam int STEP_LSB = 8;
  localparam int BUSY_BIT = 15;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_CHECK,
    SW_OFF,
    SW_ON
  } sw_state_e;
endpackage

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
module clksw_gate #(
  parameter bit RST_ON = 1'b0
) (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  output logic gate_en
);
  logic rst_a, rst_b;
  logic req_a, req_b;

  always_ff @(posedge src_clk) begin
    rst_a <= rst;
    rst_b <= rst_a;
    if (rst_b) begin
      req_a <= RST_ON;
      req_b <= RST_ON;
    end else begin
      req_a <= req;
      req_b <= req_a;
    end
  end

  // enable moves only while the source clock is low
  always_ff @(negedge src_clk) begin
    if (rst_b) gate_en <= RST_ON;
    else       gate_en <= req_b;
  end
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SRC_N  = 8,
  parameter int SEL_W  = 3,
  parameter int DIV_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic [SRC_N-1:0]  gate_en,
  input  logic [SRC_N-1:0]  src_rdy,
  output logic [SRC_N-1:0]  gate_req,
  output logic [DIV_W-1:0]  div_tgt,
  output logic              fup_en,
  output logic              fdn_en,
  output logic [STEP_W-1:0] step,
  output logic              div_req_t,
  input  logic              div_ack_t
);
  localparam int FUP_BIT = DIV_W;
  localparam int FDN_BIT = DIV_W + 1;

  sw_state_e          state;
  logic [SEL_W-1:0]   new_q, cur_q;
  logic               swen;
  logic [SRC_N-1:0]   rdy_s1, rdy_s2, st_s1, st_s2;
  logic               ack_s1, ack_s2;
  logic               busy;
  logic               wr0, wr1;
  logic [REG_W-1:0]   reg0_v, reg1_v;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^wr_data;
  assign wr0  = wr_en && !wr_sel;
  assign wr1  = wr_en && wr_sel;
  assign busy = div_req_t ^ ack_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_s1 <= '0; rdy_s2 <= '0;
      st_s1  <= '0; st_s2  <= '0;
      ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      rdy_s1 <= src_rdy;  rdy_s2 <= rdy_s1;
      st_s1  <= gate_en;  st_s2  <= st_s1;
      ack_s1 <= div_ack_t; ack_s2 <= ack_s1;
    end
  end

  // source switch sequencing: check, gate old off, gate new on
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SW_IDLE;
      new_q    <= '0;
      cur_q    <= '0;
      swen     <= 1'b0;
      gate_req <= SRC_N'(1);
    end else begin
      case (state)
        SW_IDLE: begin
          if (wr0) begin
            new_q <= wr_data[SEL_W-1:0];
            if (wr_data[SWEN_BIT]) begin
              swen  <= 1'b1;
              state <= SW_CHECK;
            end
          end
        end
        SW_CHECK: begin
          if (!rdy_s2[new_q] || new_q == cur_q) begin
            swen  <= 1'b0;
            state <= SW_IDLE;
          end else begin
            gate_req <= '0;
            state    <= SW_OFF;
          end
        end
        SW_OFF: begin
          if (!st_s2[cur_q]) begin
            gate_req <= SRC_N'(1) << new_q;
            state    <= SW_ON;
          end
        end
        SW_ON: begin
          if (st_s2[new_q]) begin
            cur_q <= new_q;
            swen  <= 1'b0;
            state <= SW_IDLE;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // divider settings: locked while a change is in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      div_tgt   <= '0;
      fup_en    <= 1'b0;
      fdn_en    <= 1'b0;
      step      <= '0;
      div_req_t <= 1'b0;
    end else if (wr1 && !busy) begin
      div_tgt   <= wr_data[DIV_W-1:0];
      fup_en    <= wr_data[FUP_BIT];
      fdn_en    <= wr_data[FDN_BIT];
      step      <= wr_data[STEP_LSB +: STEP_W];
      div_req_t <= ~div_req_t;
    end
  end

  always_comb begin
    reg0_v = '0;
    reg0_v[SEL_W-1:0]          = new_q;
    reg0_v[CUR_LSB +: SEL_W]   = cur_q;
    reg0_v[SWEN_BIT]           = swen;
    reg1_v = '0;
    reg1_v[DIV_W-1:0]          = div_tgt;
    reg1_v[FUP_BIT]            = fup_en;
    reg1_v[FDN_BIT]            = fdn_en;
    reg1_v[STEP_LSB +: STEP_W] = step;
    reg1_v[BUSY_BIT]           = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? reg1_v : reg0_v;
  end

  a_r3_refused_keeps_source: assert property (@(posedge clk) disable iff (rst)
    (state == SW_CHECK && !rdy_s2[new_q]) |=> (!swen && $stable(cur_q)));

  a_r4_start_bit_clears: assert property (@(posedge clk) disable iff (rst)
    (state == SW_ON && st_s2[new_q]) |=> (!swen && cur_q == $past(new_q)));

  a_r11_single_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_s2));

  a_r7_locked_when_busy: assert property (@(posedge clk) disable iff (rst)
    (wr1 && busy) |=> ($stable(div_tgt) && $stable(step)));
endmodule

// File: rtl/clksw_div.sv
`timescale 1ns/1ps
module clksw_div #(
  parameter int DIV_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic              mclk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_tgt,
  input  logic              fup_en,
  input  logic              fdn_en,
  input  logic [STEP_W-1:0] step,
  input  logic              req_t,
  output logic              ack_t,
  output logic              out_en
);
  localparam int EW = DIV_W + 1;

  logic              rst_a, rst_b, seen_rst;
  logic              t1, t2, t3;
  logic [EW-1:0]     eff, cnt, tgt_m, nxt;
  logic [STEP_W-1:0] hold, step_m;
  logic              pend, up_m, dn_m;
  logic              wrap, go_down, allow;

  assign wrap    = (cnt == eff - EW'(1));
  assign go_down = (tgt_m < eff);
  assign allow   = go_down ? up_m : dn_m;
  assign nxt     = go_down ? eff - EW'(1) : eff + EW'(1);

  always_ff @(posedge mclk) begin
    rst_a <= rst;
    rst_b <= rst_a;
    if (rst_b) seen_rst <= 1'b1;
  end

  always_ff @(posedge mclk) begin
    if (rst_b) begin
      t1 <= 1'b0; t2 <= 1'b0; t3 <= 1'b0;
      eff    <= EW'(1);
      cnt    <= '0;
      tgt_m  <= EW'(1);
      hold   <= '0;
      step_m <= '0;
      pend   <= 1'b0;
      up_m   <= 1'b0;
      dn_m   <= 1'b0;
      ack_t  <= 1'b0;
    end else begin
      t1 <= req_t;
      t2 <= t1;
      t3 <= t2;
      cnt <= wrap ? '0 : cnt + EW'(1);
      if (t2 != t3) begin
        pend   <= 1'b1;
        tgt_m  <= EW'(div_tgt) + EW'(1);
        up_m   <= fup_en;
        dn_m   <= fdn_en;
        step_m <= step;
        hold   <= '0;
      end else if (pend && wrap) begin
        if (hold != '0) begin
          hold <= hold - STEP_W'(1);
        end else if (eff == tgt_m) begin
          pend  <= 1'b0;
          ack_t <= ~ack_t;
        end else if (!allow) begin
          eff   <= tgt_m;
          pend  <= 1'b0;
          ack_t <= ~ack_t;
        end else begin
          eff  <= nxt;
          hold <= step_m;
          if (nxt == tgt_m) begin
            pend  <= 1'b0;
            ack_t <= ~ack_t;
          end
        end
      end
    end
  end

  // output enable changes only while the muxed clock is low
  always_ff @(negedge mclk) begin
    if (rst_b) out_en <= 1'b0;
    else       out_en <= (cnt == '0);
  end

  a_r5_count_in_range: assert property (@(posedge mclk) disable iff (rst_b || !seen_rst)
    cnt < eff);

  a_r5_change_on_boundary: assert property (@(posedge mclk) disable iff (rst_b || !seen_rst)
    (eff != $past(eff)) |-> $past(wrap));

  a_r8_unit_steps: assert property (@(posedge mclk) disable iff (rst_b || !seen_rst)
    (eff != $past(eff) && eff != $past(tgt_m)) |->
      (eff == $past(eff) + EW'(1) || eff == $past(eff) - EW'(1)));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch #(
  parameter int SRC_N  = 8,
  parameter int DIV_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             rd_sel,
  output logic [15:0]      rd_data,
  input  logic [SRC_N-1:0] src_clk,
  input  logic [SRC_N-1:0] src_rdy,
  output logic             clk_out
);
  localparam int SEL_W = $clog2(SRC_N);

  logic [SRC_N-1:0]  gate_req, gate_en;
  logic [DIV_W-1:0]  div_tgt;
  logic              fup_en, fdn_en, div_req_t, div_ack_t, out_en;
  logic [STEP_W-1:0] step;
  logic              mclk;

  clksw_ctrl #(
    .SRC_N(SRC_N), .SEL_W(SEL_W), .DIV_W(DIV_W), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .gate_en(gate_en), .src_rdy(src_rdy),
    .gate_req(gate_req), .div_tgt(div_tgt), .fup_en(fup_en), .fdn_en(fdn_en),
    .step(step), .div_req_t(div_req_t), .div_ack_t(div_ack_t)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_cell
    clksw_gate #(.RST_ON(i == 0)) u_gate (
      .src_clk(src_clk[i]), .rst(rst), .req(gate_req[i]), .gate_en(gate_en[i])
    );
  end

  assign mclk = |(src_clk & gate_en);

  clksw_div #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_div (
    .mclk(mclk), .rst(rst), .div_tgt(div_tgt), .fup_en(fup_en), .fdn_en(fdn_en),
    .step(step), .req_t(div_req_t), .ack_t(div_ack_t), .out_en(out_en)
  );

  assign clk_out = mclk & out_en;
endmodule

// File: tb/test_sysclk_switch.sv
`timescale 1ns/1ps
module test_sysclk_switch;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [N-1:0] rdy = '1;
  logic [N-1:0] src_clk;
  logic        clk_out;

  int checks = 0, errors = 0;
  int cur_src = 0;
  bit done = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic c = 1'b0;
    always #(5.0 + g) c = ~c;
    assign src_clk[g] = c;
  end

  sysclk_switch i_sysclk_switch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .src_clk(src_clk), .src_rdy(rdy),
    .clk_out(clk_out)
  );

  function automatic real tsrc(input int i);
    return 10.0 + 2.0 * i;
  endfunction

  // edge recorder and phase monitor
  real tq [0:511];
  int  tn = 0;
  bit  rec = 0;
  bit  mon = 0;
  int  glitches = 0;
  real t_r = 0.0, t_f = 0.0;

  always @(posedge clk_out) begin
    if (rec && tn < 512) begin tq[tn] = $realtime; tn++; end
    if (mon && ($realtime - t_f) < 4.9) glitches++;
    t_r = $realtime;
  end
  always @(negedge clk_out) begin
    if (mon && ($realtime - t_r) < 4.9) glitches++;
    t_f = $realtime;
  end

  function automatic int per(input int k, input int src);
    return $rtoi((tq[k+1] - tq[k]) / tsrc(src) + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [15:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_swen(output bit ok);
    logic [15:0] v;
    ok = 0;
    for (int k = 0; k < 500; k++) begin
      rd(1'b0, v);
      if (!v[7]) begin ok = 1; return; end
    end
  endtask

  task automatic wait_busy(output bit ok);
    logic [15:0] v;
    ok = 0;
    for (int k = 0; k < 500; k++) begin
      rd(1'b1, v);
      if (!v[15]) begin ok = 1; return; end
    end
  endtask

  task automatic period_of(input int src, output int cyc);
    real t0;
    @(posedge clk_out);
    @(posedge clk_out);
    t0 = $realtime;
    @(posedge clk_out);
    cyc = $rtoi(($realtime - t0) / tsrc(src) + 0.5);
  endtask

  task automatic set_div(input int d);
    bit ok;
    wr(1'b1, 16'(d - 1));
    wait_busy(ok);
    check(ok, "R6 busy clears", int'(ok), 1);
  endtask

  task automatic switch_to(input int s, input int d);
    bit ok; logic [15:0] v; int p;
    wr(1'b0, 16'(s | 128));
    wait_swen(ok);
    check(ok, "R4 start bit cleared", int'(ok), 1);
    rd(1'b0, v);
    check(v[6:4] == 3'(s), "R2 current source", int'(v[6:4]), s);
    cur_src = s;
    period_of(s, p);
    check(p == d, "R2 output period", p, d);
  endtask

  task automatic slew_run(input int od, input int nd, input bit fup, input bit fdn,
                          input int stp, input string tag);
    int ex [0:255];
    int en, v, dir, k, j, p, e, bad, act_b, exp_b;
    bit allow, ok;
    set_div(od);
    tn = 0; rec = 1;
    wr(1'b1, 16'((nd - 1) | (int'(fup) << 4) | (int'(fdn) << 5) | (stp << 8)));
    wait_busy(ok);
    repeat (3) @(posedge clk_out);
    rec = 0;
    dir   = (nd < od) ? -1 : 1;
    allow = (nd < od) ? fup : fdn;
    en = 0;
    if (allow) begin
      v = od;
      while (v != nd) begin
        v += dir;
        if (v != nd)
          for (int q = 0; q <= stp; q++) begin ex[en] = v; en++; end
      end
    end
    ex[en] = nd; en++;
    k = 0;
    while (k < tn - 1 && per(k, cur_src) == od) k++;
    bad = 0; j = 0; act_b = 0; exp_b = 0;
    while (k < tn - 1) begin
      p = per(k, cur_src);
      e = (j < en) ? ex[j] : nd;
      if (p != e) begin
        if (bad == 0) begin act_b = p; exp_b = e; end
        bad++;
      end
      j++; k++;
    end
    if (j < en) begin
      if (bad == 0) begin act_b = j; exp_b = en; end
      bad++;
    end
    check(ok && bad == 0, tag, act_b, exp_b);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int p;
    bit ok;
    repeat (20) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    mon = 1;

    // R1 reset state
    rd(1'b0, v);
    check(v[2:0] == 0, "R1 requested source", int'(v[2:0]), 0);
    check(v[6:4] == 0, "R1 current source", int'(v[6:4]), 0);
    check(v[7] == 0, "R1 start bit", int'(v[7]), 0);
    rd(1'b1, v);
    check(v[3:0] == 0, "R1 divider field", int'(v[3:0]), 0);
    check(v[15] == 0, "R1 busy", int'(v[15]), 0);
    period_of(0, p);
    check(p == 1, "R1 output from source 0", p, 1);

    // R2 sweep over every source
    for (int s = 1; s < N; s++) switch_to(s, 1);
    switch_to(0, 1);
    switch_to(3, 1);

    // R5 divisor sweep
    for (int d = 0; d < 16; d++) begin
      wr(1'b1, 16'(d));
      wait_busy(ok);
      check(ok, "R6 busy clears", int'(ok), 1);
      rd(1'b1, v);
      check(v[3:0] == 4'(d), "R5 divider field", int'(v[3:0]), d);
      period_of(3, p);
      check(p == d + 1, "R5 divided period", p, d + 1);
    end

    // R6 busy visible during a change from /16 to /1
    wr(1'b1, 16'd0);
    rd(1'b1, v);
    check(v[15] == 1, "R6 busy after write", int'(v[15]), 1);
    wait_busy(ok);
    check(ok, "R6 busy returns low", int'(ok), 1);
    period_of(3, p);
    check(p == 1, "R6 divisor in effect", p, 1);

    // R7 second write during busy is dropped
    set_div(8);
    wr(1'b1, 16'd2);
    wr(1'b1, 16'd12);
    wait_busy(ok);
    rd(1'b1, v);
    check(v[3:0] == 2, "R7 ignored write field", int'(v[3:0]), 2);
    period_of(3, p);
    check(p == 3, "R7 ignored write period", p, 3);

    // R3 refused switch
    rdy[5] = 1'b0;
    repeat (5) @(negedge clk);
    wr(1'b0, 16'(5 | 128));
    wait_swen(ok);
    check(ok, "R3 start bit cleared on refusal", int'(ok), 1);
    rd(1'b0, v);
    check(v[6:4] == 3, "R3 current source kept", int'(v[6:4]), 3);
    period_of(3, p);
    check(p == 3, "R3 output unchanged", p, 3);
    rdy[5] = 1'b1;
    repeat (5) @(negedge clk);

    // R4 write to register 0 during an attempt is ignored
    wr(1'b0, 16'(6 | 128));
    wr(1'b0, 16'(1 | 128));
    wait_swen(ok);
    rd(1'b0, v);
    check(v[2:0] == 6, "R4 requested field kept", int'(v[2:0]), 6);
    check(v[6:4] == 6, "R4 switch target kept", int'(v[6:4]), 6);
    cur_src = 6;
    period_of(6, p);
    check(p == 3, "R2 divided period after switch", p, 3);

    // R8, R9, R10 walking
    slew_run(2, 7, 1'b0, 1'b1, 1, "R8 walk to larger divisor");
    slew_run(12, 4, 1'b1, 1'b0, 2, "R9 walk to smaller divisor");
    slew_run(5, 1, 1'b1, 1'b0, 0, "R9 walk down with single-cycle hold");
    slew_run(3, 10, 1'b1, 1'b0, 1, "R10 jump up with walk-up disabled");
    slew_run(10, 3, 1'b0, 1'b1, 1, "R10 jump down with walk-down disabled");

    // R11 switch while dividing, then phase check
    switch_to(1, 3);
    switch_to(7, 3);
    check(glitches == 0, "R11 no short clock phases", glitches, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule